// File: doc/BRIEF.md
# Interrupt Set/Clear Enable Bank

This block holds one enable flag per interrupt and places them behind a small memory-mapped register bus. Two address windows reach the same flags. A write to the set window turns on every interrupt whose data bit is 1. A write to the clear window turns off every interrupt whose data bit is 1. Bits written as 0 change nothing in either window. A read from either window returns the present enable flags. No access can overwrite the flags wholesale.

The bus presents a byte address, a size code, write data and a read or write strobe. Each access covers eight interrupts per byte. Byte 0 of the data word holds the lowest-numbered interrupts. The full enable vector goes to downstream logic. A one-cycle "newly enabled" flag fires for every interrupt that a set-window write targets, so that a queueing stage can pick it up again.

Top module: `irq_enable_bank`

## Requirements
- R1: While `rst` is high at a clock edge, all enable flags, all newly-enabled flags and `bus_rdata` become 0 at that edge.
- R2: The first interrupt of an access is 8 × (address − window start). The access covers 8 × bytes interrupts. Data bit i maps to interrupt first+i. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Data bits above 8 × bytes are ignored.
- R3: A legal write to the set window enables each covered interrupt whose data bit is 1 and leaves the others unchanged. `enable_o` shows the result in the cycle after the write edge.
- R4: A legal write to the clear window disables each covered interrupt whose data bit is 1 and leaves the others unchanged. `enable_o` shows the result in the cycle after the write edge.
- R5: A legal read from either window returns the enable flags of the covered interrupts in `bus_rdata`, with bit i showing interrupt first+i and the bits above 8 × bytes at 0. The data is valid in the cycle after the read strobe. In a cycle that does not follow a read strobe, `bus_rdata` is 0.
- R6: For each interrupt targeted with a 1 bit by a legal set-window write, `newly_en_o` is high for exactly the cycle after the write edge. This holds even when the interrupt was already enabled. Reads and clear-window writes raise no flag.
- R7: Interrupt numbers at or above `NUM_IRQ` read as 0, and writes to them have no effect.
- R8: An access is illegal if its size code is 3, if its offset is not a multiple of its byte count, if it runs past the end of its window, or if its address lies in neither window. An illegal read returns 0. An illegal write changes no flag and raises no newly-enabled flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Registered read data |
| enable_o | output | NUM_IRQ | Enable flag per interrupt |
| newly_en_o | output | NUM_IRQ | One-cycle flag per interrupt targeted by a set write |

## Verification
The bench builds the bank with `NUM_IRQ` = 40, the set window at 0x100, the clear window at 0x180, and 16 bytes per window. With 40 interrupts, the second 32-bit word is only partly populated. One access can therefore touch real and missing interrupts together, and whole words in each window lie beyond the bank. A 16-byte window also allows accesses at the last legal byte and outside both windows. Together these reach the partial-word, out-of-range and illegal-access cases alongside ordinary byte, halfword and word traffic.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Number of bytes moved by one access of the given size code.
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

  // Data lanes that carry meaning for the given size code.
  function automatic logic [BUS_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      SZ_WORD: return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/irq_en_decode.sv
module irq_en_decode
  import irq_en_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SET_BASE  = 'h100,
  parameter int CLR_BASE  = 'h180,
  parameter int WIN_BYTES = 16,
  localparam int OFF_W    = ADDR_W + 1,
  localparam int FIRST_W  = OFF_W + 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic               hit_set,
  output logic               legal,
  output logic [FIRST_W-1:0] first_irq
);

  logic [OFF_W-1:0] a_ext;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] nbytes;
  logic             in_set;
  logic             in_clr;
  logic             aligned;
  logic             fits;

  always_comb begin
    a_ext   = {1'b0, addr};
    in_set  = (a_ext >= OFF_W'(SET_BASE)) && (a_ext < OFF_W'(SET_BASE + WIN_BYTES));
    in_clr  = (a_ext >= OFF_W'(CLR_BASE)) && (a_ext < OFF_W'(CLR_BASE + WIN_BYTES));
    off     = in_set ? (a_ext - OFF_W'(SET_BASE)) : (a_ext - OFF_W'(CLR_BASE));
    nbytes  = OFF_W'(size_bytes(size));
    aligned = ((off & (nbytes - OFF_W'(1))) == '0);
    fits    = (off + nbytes) <= OFF_W'(WIN_BYTES);
    legal   = (in_set || in_clr) && (size != SZ_RSVD) && aligned && fits;
    hit_set = in_set;
    // one enable bit per interrupt: eight interrupts per byte of offset
    first_irq = {off, 3'b000};
  end

endmodule

// File: rtl/irq_en_lane.sv
module irq_en_lane
  import irq_en_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int FIRST_W = 16,
  localparam int EXT_W  = NUM_IRQ + BUS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               legal,
  input  logic               hit_set,
  input  logic [1:0]         size,
  input  logic [FIRST_W-1:0] first_irq,
  input  logic [BUS_W-1:0]   wdata,
  output logic [NUM_IRQ-1:0] set_mask,
  output logic [NUM_IRQ-1:0] clr_mask
);

  logic [BUS_W-1:0]   lane_data;
  logic [EXT_W-1:0]   spread;
  logic [NUM_IRQ-1:0] covered;

  always_comb begin
    lane_data = wdata & size_mask(size);
    // positions past the bank fall off the top of the slice
    spread    = EXT_W'(lane_data) << first_irq;
    covered   = spread[NUM_IRQ-1:0];
    set_mask  = (wr && legal && hit_set)  ? covered : '0;
    clr_mask  = (wr && legal && !hit_set) ? covered : '0;
  end

  // R8: an illegal access yields no action on any interrupt
  assert_illegal_inert_R8: assert property (@(posedge clk) disable iff (rst)
    !legal |-> (set_mask == '0 && clr_mask == '0));

  // R2: a single access acts through one window only
  assert_one_window_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(set_mask & clr_mask) == 0);

endmodule

// File: rtl/irq_en_store.sv
module irq_en_store #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] fresh_q
);

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[k]    <= 1'b0;
        fresh_q[k] <= 1'b0;
      end else begin
        // clear wins if both requests ever meet on one bit
        if (clr_mask[k])      en_q[k] <= 1'b0;
        else if (set_mask[k]) en_q[k] <= 1'b1;
        fresh_q[k] <= set_mask[k] && !clr_mask[k];
      end
    end

    assert_set_enables_R3: assert property (@(posedge clk) disable iff (rst)
      (set_mask[k] && !clr_mask[k]) |=> (en_q[k] && fresh_q[k]));

    assert_clr_disables_R4: assert property (@(posedge clk) disable iff (rst)
      clr_mask[k] |=> (!en_q[k] && !fresh_q[k]));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!set_mask[k] && !clr_mask[k]) |=> ($stable(en_q[k]) && !fresh_q[k]));

    assert_flag_implies_on_R6: assert property (@(posedge clk) disable iff (rst)
      fresh_q[k] |-> en_q[k]);
  end

endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_en_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int ADDR_W    = 12,
  parameter int SET_BASE  = 'h100,
  parameter int CLR_BASE  = 'h180,
  parameter int WIN_BYTES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] newly_en_o
);

  localparam int FIRST_W = ADDR_W + 4;
  localparam int EXT_W   = NUM_IRQ + BUS_W;

  logic               hit_set;
  logic               legal;
  logic [FIRST_W-1:0] first_irq;
  logic [NUM_IRQ-1:0] set_mask;
  logic [NUM_IRQ-1:0] clr_mask;
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] fresh_q;
  logic [EXT_W-1:0]   rd_spread;
  logic [BUS_W-1:0]   rd_word;

  irq_en_decode #(
    .ADDR_W(ADDR_W), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_decode (
    .addr(bus_addr), .size(bus_size),
    .hit_set(hit_set), .legal(legal), .first_irq(first_irq)
  );

  irq_en_lane #(.NUM_IRQ(NUM_IRQ), .FIRST_W(FIRST_W)) u_lane (
    .clk(clk), .rst(rst), .wr(bus_wr), .legal(legal), .hit_set(hit_set),
    .size(bus_size), .first_irq(first_irq), .wdata(bus_wdata),
    .set_mask(set_mask), .clr_mask(clr_mask)
  );

  irq_en_store #(.NUM_IRQ(NUM_IRQ)) u_store (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .en_q(en_q), .fresh_q(fresh_q)
  );

  // read view: both windows see the same flags; missing interrupts shift in as 0
  always_comb begin
    rd_spread = EXT_W'(en_q) >> first_irq;
    rd_word   = rd_spread[BUS_W-1:0] & size_mask(bus_size);
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_rd && legal) bus_rdata <= rd_word;
    else                      bus_rdata <= '0;
  end

  assign enable_o   = en_q;
  assign newly_en_o = fresh_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (enable_o == '0 && newly_en_o == '0 && bus_rdata == '0));

  assert_rdata_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_illegal_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !legal) |=> (bus_rdata == '0));

  assert_read_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> (newly_en_o == '0 && $stable(enable_o)));

endmodule

// File: tb/test_irq_enable_bank.sv
`timescale 1ns/1ps
module test_irq_enable_bank;

  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [1:0]    bus_size = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  enable_o;
  logic [N-1:0]  newly_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_enable_bank #(
    .NUM_IRQ(N), .ADDR_W(12), .SET_BASE('h100), .CLR_BASE('h180), .WIN_BYTES(16)
  ) i_irq_enable_bank (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enable_o(enable_o), .newly_en_o(newly_en_o)
  );

  typedef struct packed {
    logic         wr;
    logic [11:0]  addr;
    logic [1:0]   size;
    logic [31:0]  wdata;
    logic [31:0]  exp_rd;
    logic [N-1:0] exp_en;
    logic [N-1:0] exp_fl;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    // R3 word set, low word
    '{1'b1, 12'h100, 2'd2, 32'h0000_00F1, 32'h0, 40'h00_0000_00F1, 40'h00_0000_00F1, 4'd3},
    // R5 read through clear window
    '{1'b0, 12'h180, 2'd2, 32'h0,         32'hF1, 40'h00_0000_00F1, 40'h0, 4'd5},
    // R7 set word half beyond the bank
    '{1'b1, 12'h104, 2'd2, 32'hFFFF_FFFF, 32'h0, 40'hFF_0000_00F1, 40'hFF_0000_0000, 4'd7},
    // R7 upper word reads only existing ids
    '{1'b0, 12'h184, 2'd2, 32'h0,         32'hFF, 40'hFF_0000_00F1, 40'h0, 4'd7},
    // R4 byte clear of ids 0 and 4
    '{1'b1, 12'h180, 2'd0, 32'h0000_0011, 32'h0, 40'hFF_0000_00E0, 40'h0, 4'd4},
    // R5 halfword read
    '{1'b0, 12'h100, 2'd1, 32'h0,         32'h00E0, 40'hFF_0000_00E0, 40'h0, 4'd5},
    // R2 byte set at offset 1 -> ids 8..15
    '{1'b1, 12'h101, 2'd0, 32'h0000_00A5, 32'h0, 40'hFF_0000_A5E0, 40'h00_0000_A500, 4'd2},
    // R2 halfword set at offset 2, upper data ignored
    '{1'b1, 12'h102, 2'd1, 32'hFFFF_1234, 32'h0, 40'hFF_1234_A5E0, 40'h00_1234_0000, 4'd2},
    // R5 word read
    '{1'b0, 12'h100, 2'd2, 32'h0,         32'h1234_A5E0, 40'hFF_1234_A5E0, 40'h0, 4'd5},
    // R7 clear of ids 48..63 has no effect
    '{1'b1, 12'h186, 2'd1, 32'h0000_FFFF, 32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd7},
    // R7 read of ids 64..95
    '{1'b0, 12'h108, 2'd2, 32'h0,         32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd7},
    // R8 misaligned word write
    '{1'b1, 12'h101, 2'd2, 32'hFFFF_FFFF, 32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R8 misaligned halfword clear
    '{1'b1, 12'h181, 2'd1, 32'hFFFF_FFFF, 32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R8 misaligned word read
    '{1'b0, 12'h102, 2'd2, 32'h0,         32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R8 reserved size code
    '{1'b1, 12'h100, 2'd3, 32'hFFFF_FFFF, 32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R8 write between windows
    '{1'b1, 12'h110, 2'd2, 32'hFFFF_FFFF, 32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R8 read between windows
    '{1'b0, 12'h110, 2'd2, 32'h0,         32'h0, 40'hFF_1234_A5E0, 40'h0, 4'd8},
    // R4 byte clear of ids 16..23
    '{1'b1, 12'h182, 2'd0, 32'h0000_00FF, 32'h0, 40'hFF_1200_A5E0, 40'h0, 4'd4},
    // R6 set of an already enabled id still flags
    '{1'b1, 12'h100, 2'd0, 32'h0000_0020, 32'h0, 40'hFF_1200_A5E0, 40'h00_0000_0020, 4'd6},
    // R5 byte read of ids 32..39
    '{1'b0, 12'h184, 2'd0, 32'h0,         32'hFF, 40'hFF_1200_A5E0, 40'h0, 4'd5},
    // R7 last legal byte of clear window, ids 120..127
    '{1'b0, 12'h18F, 2'd0, 32'h0,         32'h0, 40'hFF_1200_A5E0, 40'h0, 4'd7},
    // R2 byte read at offset 2 -> ids 16..23
    '{1'b0, 12'h182, 2'd0, 32'h0,         32'h00, 40'hFF_1200_A5E0, 40'h0, 4'd2}
  };

  task automatic chk(input string what, input int req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("reset enables", 1, 64'(enable_o), 64'h0);
    chk("reset flags", 1, 64'(newly_en_o), 64'h0);
    chk("reset rdata", 1, 64'(bus_rdata), 64'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].wr, VEC[v].addr, VEC[v].size, VEC[v].wdata);
      chk($sformatf("vec %0d rdata", v), int'(VEC[v].req), 64'(bus_rdata), 64'(VEC[v].exp_rd));
      chk($sformatf("vec %0d enables", v), int'(VEC[v].req), 64'(enable_o), 64'(VEC[v].exp_en));
      chk($sformatf("vec %0d flags", v), int'(VEC[v].req), 64'(newly_en_o), 64'(VEC[v].exp_fl));
    end

    // R6 flag lasts only one cycle
    @(negedge clk);
    chk("flag drops after idle", 6, 64'(newly_en_o), 64'h0);
    chk("enables hold when idle", 3, 64'(enable_o), 64'hFF_1200_A5E0);

    // R1 reset overrides a concurrent set write
    rst = 1'b1;
    bus_wr = 1'b1; bus_addr = 12'h100; bus_size = 2'd2; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    chk("reset during write, enables", 1, 64'(enable_o), 64'h0);
    chk("reset during write, flags", 1, 64'(newly_en_o), 64'h0);
    idle();
    rst = 1'b0;
    @(negedge clk);

    // R3 bank works again after reset; R4 full clear word
    access(1'b1, 12'h104, 2'd0, 32'h0000_0080);
    chk("set id 39 after reset", 3, 64'(enable_o), 64'h80_0000_0000);
    chk("flag id 39", 6, 64'(newly_en_o), 64'h80_0000_0000);
    access(1'b1, 12'h184, 2'd2, 32'hFFFF_FFFF);
    chk("clear upper word", 4, 64'(enable_o), 64'h0);
    access(1'b0, 12'h104, 2'd2, 32'h0);
    chk("read after clear", 5, 64'(bus_rdata), 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule